// File: doc/BRIEF.md
# DAC Channel Data Register Front End

This block holds the conversion values for a multi-channel 12-bit digital-to-analog converter, and the host loads them over an 8-bit peripheral bus. Each value arrives as two bytes. A low-byte write parks its byte in one temporary register that all channels share. A high-byte write then combines that parked byte with the incoming byte and commits the whole value to the addressed channel in a single clock. The converter never sees a half-updated value.

A mode input picks how the 12 bits sit across the two bytes. Right adjustment is the default. Left adjustment lets software run 8-bit conversions by writing the high byte alone. Each channel has an empty flag, which is also its DMA request. The flag drops when a value is committed. It rises again when a trigger pulse for that channel moves the pending value onto the converter output. Writing while the flag is low silently replaces the pending value.

Top module: `dac_chan_regs`

## Requirements
- R1: After reset, every pending value, the shared temporary byte and every converter output are zero. Every empty flag and DMA request is 1, and every readback byte is zero.
- R2: The address is decoded as follows. Bit 0 selects the byte (0 is the low byte, 1 is the high byte), and the bits above it select the channel. With `left_adj`=0, a high-byte write commits the value {high[3:0], temp[7:0]}. The high byte's upper nibble is ignored on write. Readback gives low = value[7:0] and high = {4'b0, value[11:8]}.
- R3: With `left_adj`=1, a high-byte write commits the value {high[7:0], temp[7:4]}. The temporary byte's lower nibble is ignored. Readback gives high = value[11:4] and low = {value[3:0], 4'b0}.
- R4: A low-byte write changes only the shared temporary byte. It does not change the readback or the empty flag of any channel. The next high-byte write to any channel uses that temporary byte.
- R5: The temporary byte resets to zero, and no commit clears it. In left-adjust mode, high-byte-only writes therefore commit {high, temp[7:4]}, which after reset is {high, 4'b0}.
- R6: A commit clears that channel's empty flag in the next cycle. `dma_req` always equals `data_empty`.
- R7: When a trigger pulse arrives on a channel whose flag is clear, then in the next cycle `conv_data` for that channel holds the pending value, `conv_valid` is high for exactly one cycle, and the empty flag is set.
- R8: A trigger on a channel whose empty flag is set does nothing. `conv_valid` stays low, and `conv_data` and the flag hold.
- R9: A second commit before any trigger overwrites the pending value with no indication. The next trigger outputs the latest value.
- R10: When a trigger and a commit hit the same channel in the same cycle while the flag is clear, the old value goes to the output. The new value becomes pending, and the flag stays clear.
- R11: Readback always reflects the current `left_adj` setting. Changing the mode reformats the bytes without altering the pending value.
- R12: Channels are independent. A commit or trigger on one channel leaves the other channels' values, flags and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| left_adj | input | 1 | 1 selects left-adjusted byte packing |
| bus_addr | input | ADDR_W (2) | Bit 0 selects the byte; the upper bits select the channel |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | BUS_W (8) | Write byte |
| bus_rd_data | output | BUS_W (8) | Readback of the addressed byte (combinational) |
| conv_trig | input | NUM_CH (2) | Per-channel conversion trigger pulse |
| conv_valid | output | NUM_CH (2) | One-cycle pulse when a value is handed over |
| conv_data | output | NUM_CH*RES_W (24) | Per-channel converter value, channel 0 in the low bits |
| data_empty | output | NUM_CH (2) | Per-channel data-register-empty flag |
| dma_req | output | NUM_CH (2) | Per-channel DMA request, equal to the empty flag |

## Verification
Some behaviour is checked by the assertions on every cycle:
- A commit always clears the flag.
- A handover always sets the flag and pulses `conv_valid`.
- A trigger with the flag set leaves the output alone.
- The output changes only alongside a valid pulse.
- The temporary byte moves only on low-byte writes.
- Reserved readback bits stay zero.

The bench covers what needs an arithmetic model. It sweeps all 4096 values through each packing mode and compares the readback and output against expected values. It also runs the scenarios that show overwrite, the collision of a trigger with a commit, reformatting on a mode change, sharing of the temporary byte across channels, and 8-bit operation straight after reset.

// File: rtl/dac_chan_pkg.sv
package dac_chan_pkg;
   typedef enum logic {
      SEL_LO = 1'b0,
      SEL_HI = 1'b1
   } byte_sel_e;

   typedef enum logic {
      ADJ_RIGHT = 1'b0,
      ADJ_LEFT  = 1'b1
   } adjust_e;
endpackage

// File: rtl/dac_byte_packer.sv
module dac_byte_packer #(
   parameter int RES_W = 12,
   parameter int BUS_W = 8
) (
   input  logic             left_adj,
   input  logic [RES_W-1:0] value,
   output logic [BUS_W-1:0] lo_byte,
   output logic [BUS_W-1:0] hi_byte
);
   import dac_chan_pkg::*;
   localparam int EXT_W = RES_W - BUS_W;

   generate
      if (EXT_W < 1 || EXT_W > BUS_W) begin : g_bad
         $error("dac_byte_packer: RES_W must lie in (BUS_W, 2*BUS_W]");
      end
   endgenerate

   always_comb begin
      lo_byte = '0;
      hi_byte = '0;
      if (adjust_e'(left_adj) == ADJ_LEFT) begin
         hi_byte                   = value[RES_W-1 -: BUS_W];
         lo_byte[BUS_W-1 -: EXT_W] = value[EXT_W-1:0];
      end else begin
         lo_byte              = value[BUS_W-1:0];
         hi_byte[EXT_W-1:0]   = value[RES_W-1:BUS_W];
      end
   end
endmodule

// File: rtl/dac_byte_unpacker.sv
module dac_byte_unpacker #(
   parameter int RES_W = 12,
   parameter int BUS_W = 8
) (
   input  logic             left_adj,
   input  logic [BUS_W-1:0] temp_byte,
   input  logic [BUS_W-1:0] hi_byte,
   output logic [RES_W-1:0] value
);
   import dac_chan_pkg::*;
   localparam int EXT_W = RES_W - BUS_W;

   always_comb begin
      if (adjust_e'(left_adj) == ADJ_LEFT)
         value = {hi_byte, temp_byte[BUS_W-1 -: EXT_W]};
      else
         value = {hi_byte[EXT_W-1:0], temp_byte};
   end
endmodule

// File: rtl/dac_chan_slot.sv
module dac_chan_slot #(
   parameter int RES_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             commit,
   input  logic [RES_W-1:0] commit_value,
   input  logic             trig,
   output logic [RES_W-1:0] pend_value,
   output logic [RES_W-1:0] conv_data,
   output logic             conv_valid,
   output logic             empty
);
   logic handover;
   assign handover = trig && !empty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_value <= '0;
         conv_data  <= '0;
         conv_valid <= 1'b0;
         empty      <= 1'b1;
      end else begin
         conv_valid <= 1'b0;
         if (handover) begin
            conv_data  <= pend_value;
            conv_valid <= 1'b1;
            empty      <= 1'b1;
         end
         if (commit) begin
            pend_value <= commit_value;
            empty      <= 1'b0;
         end
      end
   end

   AST_COMMIT_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !empty); // R6
   AST_HANDOVER_SETS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && !empty && !commit) |=> (empty && conv_valid)); // R7
   AST_EMPTY_RISE_NEEDS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(empty) |-> $past(trig)); // R7
   AST_CONV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_valid |-> $stable(conv_data)); // R7
   AST_IDLE_TRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && empty && !commit) |=> (!conv_valid && empty)); // R8
   AST_COLLIDE_OLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && !empty && commit) |=> (conv_valid && !empty && conv_data == $past(pend_value))); // R10
endmodule

// File: rtl/dac_chan_regs.sv
module dac_chan_regs #(
   parameter int NUM_CH = 2,
   parameter int RES_W  = 12,
   parameter int BUS_W  = 8,
   parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   parameter int ADDR_W = CH_W + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    left_adj,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic                    bus_wr_en,
   input  logic [BUS_W-1:0]        bus_wr_data,
   output logic [BUS_W-1:0]        bus_rd_data,
   input  logic [NUM_CH-1:0]       conv_trig,
   output logic [NUM_CH-1:0]       conv_valid,
   output logic [NUM_CH*RES_W-1:0] conv_data,
   output logic [NUM_CH-1:0]       data_empty,
   output logic [NUM_CH-1:0]       dma_req
);
   import dac_chan_pkg::*;
   localparam int EXT_W = RES_W - BUS_W;
   localparam logic [CH_W:0] CH_CNT = (CH_W+1)'(NUM_CH);

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("dac_chan_regs: NUM_CH must be at least 1");
      end
      if (ADDR_W != CH_W + 1) begin : g_bad_addr
         $error("dac_chan_regs: ADDR_W must equal CH_W+1");
      end
   endgenerate

   byte_sel_e        sel;
   logic [CH_W-1:0]  ch_idx;
   logic             addr_ok;
   logic             lo_wr;
   logic [BUS_W-1:0] temp_q;
   logic [RES_W-1:0] new_value;
   logic [BUS_W-1:0] rd_lo [NUM_CH];
   logic [BUS_W-1:0] rd_hi [NUM_CH];
   logic [NUM_CH-1:0] empty_w;

   assign sel     = byte_sel_e'(bus_addr[0]);
   assign ch_idx  = bus_addr[ADDR_W-1:1];
   assign addr_ok = ({1'b0, ch_idx} < CH_CNT);
   assign lo_wr   = bus_wr_en && addr_ok && (sel == SEL_LO);

   always_ff @(posedge clk) begin
      if (!rst_n)     temp_q <= '0;
      else if (lo_wr) temp_q <= bus_wr_data;
   end

   dac_byte_unpacker #(.RES_W(RES_W), .BUS_W(BUS_W)) unpack_i (
      .left_adj (left_adj),
      .temp_byte(temp_q),
      .hi_byte  (bus_wr_data),
      .value    (new_value)
   );

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
         logic             commit_g;
         logic [RES_W-1:0] pend_g;
         assign commit_g = bus_wr_en && addr_ok && (sel == SEL_HI) && (ch_idx == CH_W'(g));

         dac_chan_slot #(.RES_W(RES_W)) slot_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .commit      (commit_g),
            .commit_value(new_value),
            .trig        (conv_trig[g]),
            .pend_value  (pend_g),
            .conv_data   (conv_data[g*RES_W +: RES_W]),
            .conv_valid  (conv_valid[g]),
            .empty       (empty_w[g])
         );

         dac_byte_packer #(.RES_W(RES_W), .BUS_W(BUS_W)) pack_i (
            .left_adj(left_adj),
            .value   (pend_g),
            .lo_byte (rd_lo[g]),
            .hi_byte (rd_hi[g])
         );
      end
   endgenerate

   always_comb begin
      bus_rd_data = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (addr_ok && ch_idx == CH_W'(i))
            bus_rd_data = (sel == SEL_HI) ? rd_hi[i] : rd_lo[i];
      end
   end

   assign data_empty = empty_w;
   assign dma_req    = empty_w;

   AST_TEMP_ONLY_ON_LO: assert property (@(posedge clk) disable iff (!rst_n)
      !lo_wr |=> $stable(temp_q)); // R4
   AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!left_adj && bus_addr[0]) |-> (bus_rd_data[BUS_W-1:EXT_W] == '0)); // R2
endmodule

// File: tb/dac_chan_regs_tb_top.sv
`timescale 1ns/1ps
module dac_chan_regs_tb_top;
   localparam int NUM_CH = 2;
   localparam int RES_W  = 12;
   localparam int BUS_W  = 8;
   localparam int ADDR_W = 2;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    left_adj = 1'b0;
   logic [ADDR_W-1:0]       bus_addr = '0;
   logic                    bus_wr_en = 1'b0;
   logic [BUS_W-1:0]        bus_wr_data = '0;
   logic [BUS_W-1:0]        bus_rd_data;
   logic [NUM_CH-1:0]       conv_trig = '0;
   logic [NUM_CH-1:0]       conv_valid;
   logic [NUM_CH*RES_W-1:0] conv_data;
   logic [NUM_CH-1:0]       data_empty;
   logic [NUM_CH-1:0]       dma_req;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   dac_chan_regs #(.NUM_CH(NUM_CH), .RES_W(RES_W), .BUS_W(BUS_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .left_adj(left_adj), .bus_addr(bus_addr),
      .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data), .bus_rd_data(bus_rd_data),
      .conv_trig(conv_trig), .conv_valid(conv_valid), .conv_data(conv_data),
      .data_empty(data_empty), .dma_req(dma_req)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wr_data = d; bus_wr_en = 1'b1;
      @(negedge clk);
      bus_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rd_data;
   endtask

   task automatic trig(input logic [NUM_CH-1:0] m);
      @(negedge clk);
      conv_trig = m;
      @(negedge clk);
      conv_trig = '0;
   endtask

   function automatic logic [11:0] cd(input int ch);
      return conv_data[ch*RES_W +: RES_W];
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] b;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 empty", data_empty, 2'b11);
      chk("R1 dma", dma_req, 2'b11);
      chk("R1 valid", conv_valid, 2'b00);
      chk("R1 conv", conv_data, 24'h0);
      for (int a = 0; a < 4; a++) begin
         rd(a[1:0], b); chk("R1 readback", b, 8'h00);
      end

      // R8 trigger while empty
      trig(2'b11);
      chk("R8 no valid", conv_valid, 2'b00);
      chk("R8 conv hold", conv_data, 24'h0);
      chk("R8 empty hold", data_empty, 2'b11);

      // R5 8-bit left-adjusted write straight after reset
      left_adj = 1'b1;
      wr(2'b01, 8'hAB);
      rd(2'b01, b); chk("R5 hi", b, 8'hAB);
      rd(2'b00, b); chk("R5 lo", b, 8'h00);
      chk("R6 empty clr", data_empty, 2'b10);
      chk("R6 dma eq", dma_req, 2'b10);
      trig(2'b01);
      chk("R5 conv", cd(0), 12'hAB0);
      chk("R7 valid", conv_valid, 2'b01);
      @(negedge clk);
      chk("R7 valid one cycle", conv_valid, 2'b00);
      chk("R7 empty set", data_empty, 2'b11);

      // R2 exhaustive right-adjusted sweep on channel 0
      left_adj = 1'b0;
      for (int v = 0; v < 4096; v++) begin
         wr(2'b00, v[7:0]);
         wr(2'b01, {4'hA, v[11:8]});
         chk("R6 empty", data_empty[0], 1'b0);
         chk("R6 dma", dma_req[0], 1'b0);
         chk("R12 ch1 flag", data_empty[1], 1'b1);
         rd(2'b00, b); chk("R2 lo", b, v[7:0]);
         rd(2'b01, b); chk("R2 hi", b, {4'h0, v[11:8]});
         trig(2'b01);
         chk("R7 valid", conv_valid, 2'b01);
         chk("R7 conv", cd(0), v[11:0]);
         chk("R7 empty", data_empty[0], 1'b1);
      end

      // R3 exhaustive left-adjusted sweep on channel 1
      left_adj = 1'b1;
      for (int v = 0; v < 4096; v++) begin
         wr(2'b10, {v[3:0], 4'h5});
         wr(2'b11, v[11:4]);
         chk("R6 empty", data_empty[1], 1'b0);
         rd(2'b11, b); chk("R3 hi", b, v[11:4]);
         rd(2'b10, b); chk("R3 lo", b, {v[3:0], 4'h0});
         trig(2'b10);
         chk("R7 valid", conv_valid, 2'b10);
         chk("R3 conv", cd(1), v[11:0]);
         chk("R12 ch0 conv", cd(0), 12'hFFF);
      end

      // R8 trigger on empty channel after use
      trig(2'b10);
      chk("R8 no valid", conv_valid, 2'b00);
      chk("R8 conv hold", cd(1), 12'hFFF);

      // R4 shared temp, atomic update
      left_adj = 1'b0;
      wr(2'b00, 8'h23);
      wr(2'b01, 8'h01);
      wr(2'b00, 8'h55);
      rd(2'b00, b); chk("R4 ch0 lo untouched", b, 8'h23);
      rd(2'b01, b); chk("R4 ch0 hi untouched", b, 8'h01);
      chk("R4 flags", data_empty, 2'b10);
      wr(2'b11, 8'h07);
      rd(2'b10, b); chk("R4 ch1 lo shared", b, 8'h55);
      rd(2'b11, b); chk("R4 ch1 hi", b, 8'h07);
      trig(2'b11);
      chk("R12 both valid", conv_valid, 2'b11);
      chk("R4 ch0 conv", cd(0), 12'h123);
      chk("R4 ch1 conv", cd(1), 12'h755);

      // R9 overwrite
      wr(2'b00, 8'h11); wr(2'b01, 8'h01);
      wr(2'b00, 8'h22); wr(2'b01, 8'h02);
      chk("R9 empty", data_empty[0], 1'b0);
      trig(2'b01);
      chk("R9 latest", cd(0), 12'h222);

      // R10 collision
      wr(2'b00, 8'h33); wr(2'b01, 8'h03);
      wr(2'b00, 8'h44);
      @(negedge clk);
      bus_addr = 2'b01; bus_wr_data = 8'h04; bus_wr_en = 1'b1; conv_trig = 2'b01;
      @(negedge clk);
      bus_wr_en = 1'b0; conv_trig = '0;
      chk("R10 valid", conv_valid[0], 1'b1);
      chk("R10 old out", cd(0), 12'h333);
      chk("R10 empty clr", data_empty[0], 1'b0);
      rd(2'b00, b); chk("R10 new lo", b, 8'h44);
      trig(2'b01);
      chk("R10 new out", cd(0), 12'h444);

      // R11 mode switch reformats
      wr(2'b10, 8'hBC); wr(2'b11, 8'h0A);
      left_adj = 1'b1;
      rd(2'b11, b); chk("R11 left hi", b, 8'hAB);
      rd(2'b10, b); chk("R11 left lo", b, 8'hC0);
      left_adj = 1'b0;
      rd(2'b11, b); chk("R11 right hi", b, 8'h0A);
      rd(2'b10, b); chk("R11 right lo", b, 8'hBC);

      // R5 temp persists across commits in left mode
      left_adj = 1'b1;
      wr(2'b00, 8'h90);
      wr(2'b01, 8'h12);
      rd(2'b00, b); chk("R5 lo", b, 8'h90);
      wr(2'b01, 8'h34);
      trig(2'b01);
      chk("R5 persist conv", cd(0), 12'h349);
      chk("R12 ch1 pending", data_empty[1], 1'b0);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule